// File: doc/BRIEF.md
# PWM Compare Channel with Shadowed Compare Value

This block is a single compare channel of a general-purpose timer, used to produce a PWM waveform. An external up-counter supplies its value each cycle. The channel compares that value against an active compare register and drives a registered output according to one of four output modes. Software writes the compare value and a control word through a simple register port. When the shadow option is set, a new compare value stays parked in a holding register and moves to the active register only when an update event arrives. Without it, the new value takes effect at once.

A trigger input passes through a two-stage synchronizer and a rising-edge detector. In normal operation the detected edge is delayed by two more registers and leaves as `trig_evt`, which the counter logic uses, for example to restart. Counting the counter's response and the output register, that path reaches the output five clocks after the trigger. When the fast option is set and the channel is in a PWM mode, the detected edge drives the output register directly. The output then goes high three clocks after the trigger edge, whatever the comparison says.

Direction and option bits are write-protected. The direction field changes only while the channel is disabled. At lock level 3, on an output channel, the shadow and fast bits are frozen. A one-pulse flag raises `cnt_halt` after the next update event, so the counter stops after a single period. The register port and the control pins are plain single-cycle signals with no valid/ready handshake. A write is always accepted in the cycle it is presented, so the port never applies back-pressure.

Top module: `pwm_compare_channel`

## Requirements
- R1: After reset the control word reads 0x00, the compare register reads 0, `oc_out` is 0, `trig_evt` is 0 and `cnt_halt` is 0.
- R2: Control word layout (select 0): bit 7 one-pulse, bit 6 channel enable, bits 5:4 mode, bit 3 shadow enable, bit 2 fast enable, bits 1:0 direction. The compare value is at select 1. With shadow enable 0, a compare write reaches the active compare value on the next clock, and the output uses it one clock later.
- R3: With shadow enable 1, a compare write changes only the holding register. A read at select 1 returns the holding register, and the output keeps using the old active value.
- R4: With shadow enable 1, a one-cycle `upd_evt` copies the holding register into the active compare register.
- R5: Mode 2'b10 drives `oc_out` high while count < active compare. Mode 2'b11 drives it high while count >= active compare. Mode 2'b00 forces it low and mode 2'b01 forces it high. The output is registered one clock behind the count.
- R6: `oc_out` is 0 whenever channel enable is 0 or direction is not 2'b00. Direction values 01, 10 and 11 select input use.
- R7: A control write leaves the direction field unchanged if channel enable was 1 before the write.
- R8: When `lock_lvl` is 3 and direction is 2'b00, a control write leaves the shadow-enable and fast-enable bits unchanged. The other fields are still written.
- R9: With fast enable 1 and a PWM mode (2'b10 or 2'b11) on an enabled output channel, a rising edge of `trig_in` presented before clock edge k makes `oc_out` 1 after edge k+2, even when the comparison gives 0.
- R10: `trig_evt` is a single-cycle pulse, high after edge k+3 for a `trig_in` rise before edge k. With fast enable 0, the trigger does not change `oc_out`. Fast enable has no effect in the forced modes.
- R11: With one-pulse 1 and channel enable 1, an `upd_evt` sets `cnt_halt` on the next clock. Any control write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 compare value |
| wr_data | input | CNT_W | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 compare value |
| rd_data | output | CNT_W | Combinational read data |
| cnt_val | input | CNT_W | Current counter value |
| upd_evt | input | 1 | Update event pulse |
| trig_in | input | 1 | Asynchronous trigger input |
| lock_lvl | input | 2 | Lock level; 3 protects option bits |
| oc_out | output | 1 | Registered compare output |
| trig_evt | output | 1 | Delayed trigger pulse toward the counter |
| cnt_halt | output | 1 | One-pulse stop request to the counter |

## Verification
If the active compare register is wrong, it shows on `oc_out` as a duty-cycle edge at the wrong count. That shows one clock after the count crosses the value, and a read at select 1 does not reveal it when shadowing is on. A trigger pipeline that is too short or too long moves the forced pulse or `trig_evt` by whole cycles, and checks at exact edges k+2 and k+3 catch that. Corrupted protection logic shows up in the next control-word read-back.

// File: rtl/pwm_ch_pkg.sv
package pwm_ch_pkg;
  typedef enum logic [1:0] {
    OC_FORCE_LO = 2'b00,
    OC_FORCE_HI = 2'b01,
    OC_PWM_LOW  = 2'b10,
    OC_PWM_HIGH = 2'b11
  } oc_mode_e;

  typedef struct packed {
    logic     one_pulse;
    logic     ch_en;
    oc_mode_e mode;
    logic     shadow_en;
    logic     fast_en;
    logic [1:0] dir;
  } ch_ctrl_t;

  localparam int CTRL_W = 8;
  localparam logic [1:0] DIR_OUT = 2'b00;
  localparam logic [1:0] LOCK_FULL = 2'd3;
endpackage

// File: rtl/pwm_ch_ctrl.sv
module pwm_ch_ctrl
  import pwm_ch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [1:0]        lock_lvl,
  output ch_ctrl_t          ctrl
);
  ch_ctrl_t nxt;

  always_comb begin
    nxt = ctrl;
    if (wr) begin
      nxt = ch_ctrl_t'(wdata);
      if (ctrl.ch_en) nxt.dir = ctrl.dir;
      if (lock_lvl == LOCK_FULL && ctrl.dir == DIR_OUT) begin
        nxt.shadow_en = ctrl.shadow_en;
        nxt.fast_en   = ctrl.fast_en;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else        ctrl <= nxt;
  end

  // R7: direction frozen while enabled
  a_r7_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ch_en |=> (ctrl.dir == $past(ctrl.dir)));

  // R8: option bits frozen under full lock on an output channel
  a_r8_lock_opts: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_lvl == LOCK_FULL && ctrl.dir == DIR_OUT) |=>
      (ctrl.shadow_en == $past(ctrl.shadow_en) && ctrl.fast_en == $past(ctrl.fast_en)));
endmodule

// File: rtl/pwm_ch_ccr.sv
module pwm_ch_ccr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shadow_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         upd,
  output logic [W-1:0] hold_val,
  output logic [W-1:0] act_val
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_val <= '0;
      act_val  <= '0;
    end else begin
      if (wr) hold_val <= wdata;
      if (!shadow_en && wr)     act_val <= wdata;
      else if (shadow_en && upd) act_val <= hold_val;
    end
  end

  // R2: direct write path
  a_r2_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !shadow_en) |=> (act_val == $past(wdata)));

  // R3: shadowed value holds without update
  a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && !upd) |=> $stable(act_val));

  // R4: update transfers the holding register
  a_r4_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_en && upd) |=> (act_val == $past(hold_val)));
endmodule

// File: rtl/pwm_ch_trig.sv
module pwm_ch_trig #(
  parameter int SYNC_STAGES = 2,
  parameter int EVT_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic fast_edge,
  output logic trig_evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [EVT_STAGES-1:0]  dly_q;
  logic                   prev_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else        sync_q[i] <= (i == 0) ? trig_in : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign fast_edge = sync_q[SYNC_STAGES-1] & ~prev_q;

  for (genvar j = 0; j < EVT_STAGES; j++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly_q[j] <= 1'b0;
      else        dly_q[j] <= (j == 0) ? fast_edge : dly_q[(j == 0) ? 0 : j-1];
    end
  end

  assign trig_evt = dly_q[EVT_STAGES-1];

  // R10: delayed trigger is a single-cycle pulse
  a_r10_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_evt |=> !trig_evt);
endmodule

// File: rtl/pwm_ch_oc.sv
module pwm_ch_oc
  import pwm_ch_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ch_ctrl_t     ctrl,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         fast_edge,
  output logic         oc
);
  logic chan_on, is_pwm, level, force_hit;

  assign chan_on   = ctrl.ch_en && (ctrl.dir == DIR_OUT);
  assign is_pwm    = (ctrl.mode == OC_PWM_LOW) || (ctrl.mode == OC_PWM_HIGH);
  assign force_hit = ctrl.fast_en && is_pwm && fast_edge;

  always_comb begin
    unique case (ctrl.mode)
      OC_FORCE_LO: level = 1'b0;
      OC_FORCE_HI: level = 1'b1;
      OC_PWM_LOW:  level = (cnt < cmp);
      OC_PWM_HIGH: level = (cnt >= cmp);
      default:     level = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        oc <= 1'b0;
    else if (!chan_on) oc <= 1'b0;
    else               oc <= force_hit | level;
  end

  // R6: disabled or input channel drives low
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_on |=> !oc);

  // R9: fast trigger forces active level
  a_r9_fast_force: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_on && force_hit) |=> oc);
endmodule

// File: rtl/pwm_compare_channel.sv
module pwm_compare_channel
  import pwm_ch_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int EVT_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [CNT_W-1:0] rd_data,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             upd_evt,
  input  logic             trig_in,
  input  logic [1:0]       lock_lvl,
  output logic             oc_out,
  output logic             trig_evt,
  output logic             cnt_halt
);
  localparam int PAD_W = CNT_W - CTRL_W;

  ch_ctrl_t         ctrl;
  logic [CNT_W-1:0] hold_val, act_val;
  logic             fast_edge, ctrl_wr, ccr_wr;

  assign ctrl_wr = wr_en && !wr_sel;
  assign ccr_wr  = wr_en &&  wr_sel;

  pwm_ch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(wr_data[CTRL_W-1:0]),
    .lock_lvl(lock_lvl), .ctrl(ctrl)
  );

  pwm_ch_ccr #(.W(CNT_W)) u_ccr (
    .clk(clk), .rst_n(rst_n), .shadow_en(ctrl.shadow_en), .wr(ccr_wr),
    .wdata(wr_data), .upd(upd_evt), .hold_val(hold_val), .act_val(act_val)
  );

  pwm_ch_trig #(.SYNC_STAGES(SYNC_STAGES), .EVT_STAGES(EVT_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .fast_edge(fast_edge), .trig_evt(trig_evt)
  );

  pwm_ch_oc #(.W(CNT_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cnt(cnt_val), .cmp(act_val),
    .fast_edge(fast_edge), .oc(oc_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt_halt <= 1'b0;
    else if (ctrl_wr)                             cnt_halt <= 1'b0;
    else if (upd_evt && ctrl.one_pulse && ctrl.ch_en) cnt_halt <= 1'b1;
  end

  always_comb begin
    if (rd_sel) rd_data = ctrl.shadow_en ? hold_val : act_val;
    else        rd_data = {{PAD_W{1'b0}}, ctrl};
  end

  // R11: one-pulse update requests a halt
  a_r11_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !ctrl_wr && ctrl.one_pulse && ctrl.ch_en) |=> cnt_halt);
endmodule

// File: tb/tb_pwm_compare_channel.sv
`timescale 1ns/1ps
module tb_pwm_compare_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sel = 0, rd_sel = 0, upd_evt = 0, trig_in = 0;
  logic [W-1:0] wr_data = '0, cnt_val = '0, rd_data;
  logic [1:0] lock_lvl = 2'd0;
  logic oc_out, trig_evt, cnt_halt;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwm_compare_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .cnt_val(cnt_val), .upd_evt(upd_evt),
    .trig_in(trig_in), .lock_lvl(lock_lvl), .oc_out(oc_out),
    .trig_evt(trig_evt), .cnt_halt(cnt_halt)
  );

  // entry: {mode[1:0], ccr[15:0], cnt[15:0], expected}
  localparam int NV = 8;
  localparam logic [34:0] VEC [NV] = '{
    {2'b10, 16'd10, 16'd5,  1'b1},
    {2'b10, 16'd10, 16'd10, 1'b0},
    {2'b10, 16'd10, 16'd11, 1'b0},
    {2'b10, 16'd0,  16'd0,  1'b0},
    {2'b11, 16'd10, 16'd5,  1'b0},
    {2'b11, 16'd10, 16'd10, 1'b1},
    {2'b01, 16'd10, 16'd3,  1'b1},
    {2'b00, 16'd10, 16'd30, 1'b0}
  };

  function automatic logic [W-1:0] cv(logic opm, logic en, logic [1:0] md,
                                      logic sh, logic fe, logic [1:0] dr);
    return {8'h00, opm, en, md, sh, fe, dr};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd_evt = 1;
    @(negedge clk); upd_evt = 0;
  endtask

  task automatic rd(logic sel, output logic [W-1:0] d);
    rd_sel = sel; #1; d = rd_data;
  endtask

  task automatic trig_run(string req, logic [4:0] exp_oc, logic [4:0] exp_evt);
    @(negedge clk); trig_in = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk({req, " oc"}, W'(oc_out), W'(exp_oc[i]));
      chk({req, " evt"}, W'(trig_evt), W'(exp_evt[i]));
    end
    trig_in = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, r); chk("R1 ctrl", r, 0);
    rd(1, r); chk("R1 ccr", r, 0);
    chk("R1 oc", W'(oc_out), 0);
    chk("R1 evt", W'(trig_evt), 0);
    chk("R1 halt", W'(cnt_halt), 0);
    rst_n = 1;

    // R5 vector table, shadow off (R2)
    for (int i = 0; i < NV; i++) begin
      wr(0, cv(0, 1, VEC[i][34:33], 0, 0, 2'b00));
      wr(1, VEC[i][32:17]);
      cnt_val = VEC[i][16:1];
      @(negedge clk);
      chk($sformatf("R5/R2 vec %0d", i), W'(oc_out), W'(VEC[i][0]));
    end

    // R2 immediate write effect
    wr(0, cv(0, 1, 2'b10, 0, 0, 2'b00));
    cnt_val = 16'd20;
    wr(1, 16'd30); @(negedge clk);
    chk("R2 direct", W'(oc_out), 1);

    // R3 shadow: write parks, output unchanged
    wr(0, cv(0, 1, 2'b10, 1, 0, 2'b00));
    wr(1, 16'd7);
    rd(1, r); chk("R3 read hold", r, 16'd7);
    @(negedge clk);
    chk("R3 old active", W'(oc_out), 1);
    // R4 update transfers
    pulse_upd(); @(negedge clk);
    chk("R4 after update", W'(oc_out), 0);

    // R6 disabled channel
    wr(0, cv(0, 0, 2'b01, 0, 0, 2'b00)); @(negedge clk);
    chk("R6 disabled", W'(oc_out), 0);
    // R7 direction written while disabled, then frozen
    wr(0, cv(0, 1, 2'b01, 0, 0, 2'b01)); @(negedge clk);
    rd(0, r); chk("R7 dir accepted", r, cv(0, 1, 2'b01, 0, 0, 2'b01));
    chk("R6 input dir", W'(oc_out), 0);
    wr(0, cv(0, 1, 2'b01, 0, 0, 2'b00));
    rd(0, r); chk("R7 dir frozen", r, cv(0, 1, 2'b01, 0, 0, 2'b01));
    wr(0, cv(0, 0, 2'b01, 0, 0, 2'b00));
    wr(0, cv(0, 0, 2'b01, 0, 0, 2'b00));
    rd(0, r); chk("R7 dir restored", r, 0 | cv(0, 0, 2'b01, 0, 0, 2'b00));

    // R8 lock
    wr(0, cv(0, 1, 2'b10, 1, 1, 2'b00));
    lock_lvl = 2'd3;
    wr(0, cv(0, 1, 2'b11, 0, 0, 2'b00));
    rd(0, r); chk("R8 locked opts", r, cv(0, 1, 2'b11, 1, 1, 2'b00));
    lock_lvl = 2'd0;
    wr(0, cv(0, 1, 2'b10, 0, 0, 2'b00));
    rd(0, r); chk("R8 unlocked", r, cv(0, 1, 2'b10, 0, 0, 2'b00));

    // R9 fast trigger: compare gives 0 (ccr 7 vs count 20)
    wr(0, cv(0, 1, 2'b10, 0, 1, 2'b00));
    @(negedge clk);
    chk("R9 idle low", W'(oc_out), 0);
    trig_run("R9 fast", 5'b00100, 5'b01000);
    // R10 normal mode: output unaffected, pulse at k+3
    wr(0, cv(0, 1, 2'b10, 0, 0, 2'b00));
    trig_run("R10 normal", 5'b00000, 5'b01000);
    // R10 fast in forced mode has no effect
    wr(0, cv(0, 1, 2'b00, 0, 1, 2'b00));
    trig_run("R10 forced", 5'b00000, 5'b01000);

    // R11 one-pulse halt
    wr(0, cv(1, 1, 2'b10, 0, 0, 2'b00));
    chk("R11 before", W'(cnt_halt), 0);
    pulse_upd();
    chk("R11 halt", W'(cnt_halt), 1);
    wr(0, cv(0, 1, 2'b10, 0, 0, 2'b00));
    chk("R11 cleared", W'(cnt_halt), 0);
    wr(0, cv(0, 1, 2'b10, 0, 0, 2'b00));
    pulse_upd();
    chk("R11 no opm", W'(cnt_halt), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule